// File: doc/BRIEF.md
# Indexed PCI Interrupt Steering Router

This block lets software steer four active-low PCI interrupt request lines onto any of fifteen ISA interrupt numbers. It has a small register file that is reached through two adjacent I/O ports. Software writes a register number to the index port. It then reads or writes that register through the data port. Each request line has a 4-bit selector that picks its ISA IRQ number. A per-line mode bit sets whether the routed output follows the input level or gives a single-cycle pulse on each new assertion.

All registers except the lock register are closed after reset. Software opens them by writing a fixed key to the lock register. Writing any other value to the lock register closes them again. The IRQ outputs are formed combinationally from the request inputs, the selectors, the mode bits and one registered history bit per line. When several lines select the same IRQ number, their contributions are ORed together.

Top module: `pci_irq_steer`

## Requirements
- R1: A write to I/O address 0x22 loads the 8-bit index register. A read of 0x22 returns that index. Read data is registered and appears on `io_rdata` in the cycle after the clock edge that sampled `io_rd`.
- R2: After reset, `io_rdata` is 0x00 and the index is 0x00. The block is locked, every selector is 0, every mode bit is 0, and `irq_out` is all zero while no request is asserted.
- R3: A data-port (0x23) write of 0xC5 while the index is 0x03 unlocks the block. A data-port read of index 0x03 returns 0x01 when the block is unlocked and 0x00 when it is locked. This register is accessible at all times.
- R4: A data-port write of any value other than 0xC5 to index 0x03 locks the block again.
- R5: While the block is locked, data-port writes to any index other than 0x03 are ignored. Data-port reads of any such index return 0xFF.
- R6: Index 0x42 holds the selector for line 1 in bits 3:0 and for line 2 in bits 7:4. Index 0x43 holds the selector for line 3 in bits 3:0 and for line 4 in bits 7:4. Both registers read back what was written.
- R7: Index 0x44 bit n (n = 0..3) is the mode bit of line n+1, where 1 means level and 0 means edge. Bits 7:4 are not stored and read as zero.
- R8: A selector value of 0 routes its line nowhere. A value k in 1..15 drives `irq_out[k]`. `irq_out[0]` is always 0.
- R9: In level mode, the routed output is high in exactly the same cycles as its input line is low (asserted), with no clock delay.
- R10: In edge mode, the routed output goes high when the line becomes asserted and stays high only until the next rising clock edge. It stays low while the line is held asserted. Each new assertion after a release gives a new pulse.
- R11: When two or more lines select the same IRQ number, that output is the OR of their contributions.
- R12: While the block is unlocked, data-port reads of indices other than 0x03, 0x42, 0x43 and 0x44 return 0x00, and writes to those indices change nothing.
- R13: Accesses to addresses other than 0x22 and 0x23 change no register, and `io_rdata` keeps its last value whenever no read of 0x22 or 0x23 takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| intx_n | input | 4 | Active-low PCI interrupt requests, bit 0 is line 1 |
| irq_out | output | 16 | Active-high ISA IRQ outputs, bit k is IRQ k |

## Verification
The bench sweeps all 256 index values through the index port. It then walks every selector value on every line, each in isolation, in level mode. This shows up wrong nibble placement, off-by-one IRQ numbering and any leak from selector 0. Edge behaviour is tried with assert, hold, release and re-assert patterns. These separate a true single-cycle pulse from a level follower and from a pulse that does not re-arm. Register access is tried locked, unlocked and relocked, at both defined and undefined indices and at foreign addresses. This tells the lock gating apart from ordinary decode errors. Two lines that share one IRQ number check the OR fan-in against a last-writer-wins merge.

// File: rtl/steer_pkg.sv
// Package: constants shared by the steering router modules.
// Assumes an 8-bit data path and selector fields that tile a byte.
package steer_pkg;
    localparam int          DATA_W         = 8;
    localparam logic [7:0]  IDX_LOCK       = 8'h03;
    localparam logic [7:0]  IDX_ROUTE_BASE = 8'h42;
    localparam logic [7:0]  IDX_MODE       = 8'h44;
    localparam logic [7:0]  UNLOCK_KEY     = 8'hC5;
    localparam logic [7:0]  LOCKED_READ    = 8'hFF;
endpackage

// File: rtl/steer_io_regs.sv
// Module: steer_io_regs
// Index/data port decoder with a lock, selector registers and a mode register.
// Assumes single-cycle strobes and at most one access per cycle.
// Read data is registered and holds between reads.
module steer_io_regs
    import steer_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h0022,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h0023,
    parameter int N_LINES    = 4,
    parameter int SEL_W      = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          io_addr,
    input  logic                       io_wr,
    input  logic                       io_rd,
    input  logic [DATA_W-1:0]          io_wdata,
    output logic [DATA_W-1:0]          io_rdata,
    output logic [N_LINES*SEL_W-1:0]   sel_flat,
    output logic [N_LINES-1:0]         level_mode
);
    localparam int PER_REG = DATA_W / SEL_W;

    logic [DATA_W-1:0] index_q;
    logic              unlocked_q;
    logic [N_LINES-1:0] mode_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] data_rd_val;
    logic              idx_wr, data_wr, idx_rd, data_rd, open_wr;

    // Decode the strobes for the two ports.
    always_comb begin
        idx_wr  = io_wr && (io_addr == INDEX_ADDR);
        data_wr = io_wr && (io_addr == DATA_ADDR);
        idx_rd  = io_rd && (io_addr == INDEX_ADDR);
        data_rd = io_rd && (io_addr == DATA_ADDR);
        open_wr = data_wr && unlocked_q;
    end

    // Index register, written through the index port.
    always_ff @(posedge clk) begin
        if (!rst_n)       index_q <= '0;
        else if (idx_wr)  index_q <= io_wdata;
    end

    // Lock state, opened only by the key and closed by any other value.
    always_ff @(posedge clk) begin
        if (!rst_n)                               unlocked_q <= 1'b0;
        else if (data_wr && index_q == IDX_LOCK)  unlocked_q <= (io_wdata == UNLOCK_KEY);
    end

    // One selector register per line, each in its own nibble of a routing register.
    for (genvar g = 0; g < N_LINES; g++) begin : g_sel
        localparam logic [DATA_W-1:0] REG_IDX = DATA_W'(int'(IDX_ROUTE_BASE) + g / PER_REG);
        localparam int LSB = (g % PER_REG) * SEL_W;
        logic [SEL_W-1:0] sel_q;
        // Load this line's selector nibble when its register is written while open.
        always_ff @(posedge clk) begin
            if (!rst_n)                             sel_q <= '0;
            else if (open_wr && index_q == REG_IDX) sel_q <= io_wdata[LSB +: SEL_W];
        end
        assign sel_flat[g*SEL_W +: SEL_W] = sel_q;
    end

    // Mode register; only the low N_LINES bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                              mode_q <= '0;
        else if (open_wr && index_q == IDX_MODE) mode_q <= io_wdata[N_LINES-1:0];
    end

    // Value returned by a data-port read of the current index.
    always_comb begin
        data_rd_val = '0;
        if (index_q == IDX_LOCK) begin
            data_rd_val = {{(DATA_W-1){1'b0}}, unlocked_q};
        end else if (!unlocked_q) begin
            data_rd_val = LOCKED_READ;
        end else if (index_q == IDX_MODE) begin
            data_rd_val[N_LINES-1:0] = mode_q;
        end else begin
            for (int i = 0; i < N_LINES; i++) begin
                if (index_q == DATA_W'(int'(IDX_ROUTE_BASE) + i / PER_REG))
                    data_rd_val[(i % PER_REG)*SEL_W +: SEL_W] = sel_flat[i*SEL_W +: SEL_W];
            end
        end
    end

    // Registered read data, updated only by reads of the two ports.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (idx_rd)   rdata_q <= index_q;
        else if (data_rd)  rdata_q <= data_rd_val;
    end

    assign io_rdata   = rdata_q;
    assign level_mode = mode_q;
endmodule

// File: rtl/steer_line.sv
// Module: steer_line
// Trigger shaping for one request line: level follower or single-cycle edge pulse.
// Assumes req_n is already synchronous to clk.
module steer_line (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic level_mode,
    output logic active
);
    logic req;
    logic seen_q;

    assign req = ~req_n;

    // Remember whether the line was asserted at the last clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= req;
    end

    // Level mode passes the request through; edge mode keeps only a new assertion.
    always_comb begin
        active = level_mode ? req : (req && !seen_q);
    end
endmodule

// File: rtl/steer_irq_mux.sv
// Module: steer_irq_mux
// Fan-in of shaped request lines onto IRQ outputs by selector value.
// Selector 0 means not routed, so output 0 is never driven.
module steer_irq_mux #(
    parameter int N_LINES = 4,
    parameter int SEL_W   = 4,
    localparam int NUM_IRQ = 1 << SEL_W
) (
    input  logic [N_LINES-1:0]       line_act,
    input  logic [N_LINES*SEL_W-1:0] sel_flat,
    output logic [NUM_IRQ-1:0]       irq
);
    // OR every active line onto the IRQ number its selector names.
    always_comb begin
        irq = '0;
        for (int j = 1; j < NUM_IRQ; j++) begin
            for (int i = 0; i < N_LINES; i++) begin
                if (line_act[i] && sel_flat[i*SEL_W +: SEL_W] == SEL_W'(j))
                    irq[j] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pci_irq_steer.sv
// Module: pci_irq_steer (top)
// Routes active-low PCI interrupt requests onto ISA IRQ outputs under software control.
// Assumes all inputs are synchronous to clk and the reset is synchronous and active low.
module pci_irq_steer #(
    parameter int ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h0022,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h0023,
    parameter int N_LINES = 4,
    parameter int SEL_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        io_addr,
    input  logic                     io_wr,
    input  logic                     io_rd,
    input  logic [7:0]               io_wdata,
    output logic [7:0]               io_rdata,
    input  logic [N_LINES-1:0]       intx_n,
    output logic [(1<<SEL_W)-1:0]    irq_out
);
    logic [N_LINES*SEL_W-1:0] sel_flat;
    logic [N_LINES-1:0]       level_mode;
    logic [N_LINES-1:0]       line_act;

    steer_io_regs #(
        .ADDR_W(ADDR_W), .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR),
        .N_LINES(N_LINES), .SEL_W(SEL_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .sel_flat(sel_flat), .level_mode(level_mode)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        steer_line u_line (
            .clk(clk), .rst_n(rst_n), .req_n(intx_n[g]),
            .level_mode(level_mode[g]), .active(line_act[g])
        );
    end

    steer_irq_mux #(.N_LINES(N_LINES), .SEL_W(SEL_W)) u_mux (
        .line_act(line_act), .sel_flat(sel_flat), .irq(irq_out)
    );
endmodule

// File: rtl/steer_checker.sv
// Module: steer_checker
// Protocol properties of the steering router, attached to the top with bind.
// Assumes the default port addresses and register indices.
module steer_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        io_wr,
    input logic        io_rd,
    input logic [7:0]  io_wdata,
    input logic [7:0]  io_rdata,
    input logic [15:0] irq_out,
    input logic        unlocked,
    input logic [7:0]  index
);
    logic lock_wr, data_rd;
    assign lock_wr = io_wr && io_addr == 16'h0023 && index == 8'h03;
    assign data_rd = io_rd && io_addr == 16'h0023;

    assert_unlock_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && lock_wr && io_wdata == 8'hC5) |-> unlocked);

    assert_relock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && lock_wr && io_wdata != 8'hC5) |-> !unlocked);

    assert_locked_read_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && data_rd && !unlocked && index != 8'h03) |-> io_rdata == 8'hFF);

    assert_mode_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && data_rd && unlocked && index == 8'h44) |-> io_rdata[7:4] == 4'h0);

    assert_irq0_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[0] == 1'b0);

    assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !io_rd) |-> $stable(io_rdata));
endmodule

bind pci_irq_steer steer_checker u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .irq_out(irq_out),
    .unlocked(u_regs.unlocked_q), .index(u_regs.index_q)
);

// File: tb/tb_pci_irq_steer.sv
`timescale 1ns/1ps
module tb_pci_irq_steer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [3:0]  intx_n = 4'hF;
    logic [15:0] irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] rv;
    logic [7:0] route_sh [2];

    always #2.5 clk = ~clk;

    pci_irq_steer dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .intx_n(intx_n), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
        bus_wr(16'h0022, idx);
        bus_wr(16'h0023, d);
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
        bus_wr(16'h0022, idx);
        bus_rd(16'h0023, d);
    endtask

    task automatic set_sel(input int line, input logic [3:0] s);
        route_sh[line/2][(line%2)*4 +: 4] = s;
        reg_wr(8'h42 + 8'(line/2), route_sh[line/2]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        route_sh[0] = '0; route_sh[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check("R2 rdata", io_rdata, 8'h00);
        check("R2 irq", irq_out, 16'h0000);
        bus_rd(16'h0022, rv); check("R2 index", rv, 8'h00);
        reg_rd(8'h03, rv);    check("R2 locked", rv, 8'h00);
        reg_rd(8'h42, rv);    check("R5 locked read", rv, 8'hFF);
        intx_n = 4'h0; #1;    check("R2 idle routing", irq_out, 16'h0000);
        intx_n = 4'hF;

        // R1: index sweep over all 256 values
        for (int i = 0; i < 256; i++) begin
            bus_wr(16'h0022, 8'(i));
            bus_rd(16'h0022, rv);
            check("R1 index readback", rv, 32'(i));
        end

        // R5: locked writes ignored
        reg_wr(8'h42, 8'h5A);
        reg_wr(8'h44, 8'h0F);
        reg_rd(8'h44, rv); check("R5 locked read mode", rv, 8'hFF);
        // R3: unlock
        reg_wr(8'h03, 8'hC5);
        reg_rd(8'h03, rv); check("R3 unlocked", rv, 8'h01);
        reg_rd(8'h42, rv); check("R5 write ignored", rv, 8'h00);
        reg_rd(8'h44, rv); check("R5 mode ignored", rv, 8'h00);

        // R6: selector register readback
        for (int v = 0; v < 256; v += 37) begin
            reg_wr(8'h42, 8'(v));
            reg_wr(8'h43, 8'(255 - v));
            reg_rd(8'h42, rv); check("R6 reg42", rv, 32'(v));
            reg_rd(8'h43, rv); check("R6 reg43", rv, 32'(255 - v));
        end
        // R6: nibble placement through routing
        reg_wr(8'h44, 8'h0F);
        reg_wr(8'h42, 8'h21); reg_wr(8'h43, 8'h43);
        for (int l = 0; l < 4; l++) begin
            @(negedge clk); intx_n = ~(4'b1 << l); #1;
            check("R6 nibble route", irq_out, 32'(1) << (l + 1));
        end
        intx_n = 4'hF;

        // R7: mode register width
        reg_wr(8'h44, 8'hFF);
        reg_rd(8'h44, rv); check("R7 mode upper zero", rv, 8'h0F);

        // R12: undefined indices
        reg_wr(8'h45, 8'hAA);
        reg_rd(8'h45, rv); check("R12 undefined read", rv, 8'h00);
        reg_rd(8'h00, rv); check("R12 undefined read 0", rv, 8'h00);
        reg_rd(8'h44, rv); check("R12 no side effect", rv, 8'h0F);

        // R13: foreign addresses
        bus_wr(16'h0022, 8'h43);
        bus_wr(16'h0024, 8'h11);
        bus_wr(16'h0122, 8'h11);
        bus_wr(16'h0123, 8'h99);
        bus_rd(16'h0022, rv); check("R13 index kept", rv, 8'h43);
        bus_rd(16'h0021, rv); check("R13 rdata hold", rv, 8'h43);
        bus_rd(16'h0023, rv); check("R13 reg kept", rv, 8'h43);

        // R8, R9: every selector on every line, level mode
        route_sh[0] = '0; route_sh[1] = '0;
        reg_wr(8'h42, 8'h00); reg_wr(8'h43, 8'h00);
        for (int l = 0; l < 4; l++) begin
            for (int s = 0; s < 16; s++) begin
                intx_n = 4'hF;
                set_sel(l, 4'(s));
                @(negedge clk); #1;
                check("R9 level idle", irq_out, 16'h0000);
                intx_n = ~(4'b1 << l); #1;
                check("R8 selector route", irq_out, (s == 0) ? 32'h0 : (32'h1 << s));
                @(negedge clk); #1;
                check("R9 level held", irq_out, (s == 0) ? 32'h0 : (32'h1 << s));
            end
            intx_n = 4'hF;
            set_sel(l, 4'h0);
        end

        // R11: shared IRQ number
        set_sel(0, 4'd7); set_sel(2, 4'd7);
        @(negedge clk); intx_n = 4'b1110; #1; check("R11 line1 share", irq_out, 16'h0080);
        @(negedge clk); intx_n = 4'b1011; #1; check("R11 line3 share", irq_out, 16'h0080);
        @(negedge clk); intx_n = 4'b1010; #1; check("R11 both share", irq_out, 16'h0080);
        @(negedge clk); intx_n = 4'hF;

        // R10: edge mode pulse
        set_sel(2, 4'd0);
        set_sel(0, 4'd5);
        reg_wr(8'h44, 8'h00);
        @(negedge clk); intx_n[0] = 1'b0; #1;
        check("R10 pulse start", irq_out, 16'h0020);
        @(negedge clk); #1; check("R10 pulse ends", irq_out, 16'h0000);
        @(negedge clk); #1; check("R10 held low", irq_out, 16'h0000);
        intx_n[0] = 1'b1;
        @(negedge clk); intx_n[0] = 1'b0; #1;
        check("R10 re-arm", irq_out, 16'h0020);
        @(negedge clk); #1; check("R10 re-arm ends", irq_out, 16'h0000);
        intx_n = 4'hF;

        // R4: relock
        reg_wr(8'h03, 8'h00);
        reg_rd(8'h03, rv); check("R4 relocked", rv, 8'h00);
        reg_rd(8'h42, rv); check("R4 locked read", rv, 8'hFF);
        reg_wr(8'h03, 8'hC5);
        reg_wr(8'h03, 8'hC4);
        reg_rd(8'h03, rv); check("R4 near key locks", rv, 8'h00);

        finish_run();
    end
endmodule